// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle Preamble and Break

This block serialises characters onto a transmit line that rests at the high level. A host places a character into a single holding buffer with a one-cycle write strobe. At a bit-time boundary, marked by a one-cycle baud tick, the block moves the buffered character into a frame shifter and sends it least significant bit first. The frame has a low start bit, the data and a high stop bit. It is 10 bits long in 8-bit mode and 11 bits long in 9-bit mode. The extra data bit comes either from a host-supplied bit or from a parity generator set to even or odd. When parity is on in 8-bit mode, the parity bit takes the place of the top data bit.

Turning the transmitter on queues one full frame time of high level before any character is sent. Holding the break request sends frames that are all low. When the request drops, the line is held high for at least one bit before the next frame. A loopback control feeds the transmit line back to the receiver's data input in place of the external receive pin. Two flags report progress: a buffer-empty flag and a line-complete flag. An interrupt request is formed from each flag gated by its own enable. Turning the transmitter off lets the frame in flight finish and then keeps the line high.

A controller built around five states decides what the shifter does at each boundary:
- `S_IDLE` holds the line high.
- `S_PRE` sends a preamble frame.
- `S_BRK` sends a break frame.
- `S_MARK` sends a single high bit after a break.
- `S_DATA` sends a character.

A boundary is any baud tick that comes while the controller is in `S_IDLE` or while the current frame is on its last bit. At a boundary the next state is chosen in this order:
1. `S_IDLE` if the transmitter is off.
2. `S_PRE` if a preamble is queued.
3. `S_BRK` if a break is requested.
4. `S_MARK` if the state that just ended was `S_BRK`.
5. `S_DATA` if the buffer holds a character.
6. Otherwise `S_IDLE`.

Between boundaries the state does not change.

Top module: `sertx_top`

## Requirements
- R1: After reset, txd is 1, tdre is 1, tc is 1 and irq is 0.
- R2: A 0-to-1 change of tx_en queues one preamble frame: txd stays 1 for a full frame length (10 ticks with mode9=0) before any character's start bit appears, and a buffered character waits through it.
- R3: txd changes only at a clock edge where baud_tick is 1, and stays 1 while nothing is pending.
- R4: A character frame is a 0 start bit, then data bits LSB first, then a 1 stop bit. The frame is 10 bits (start, d0..d7, stop) with mode9=0 and 11 bits (start, d0..d7, ninth bit, stop) with mode9=1.
- R5: With mode9=1 and par_en=0 the ninth bit is bit9_sw. With par_en=1 it is the parity of d0..d7, and bit9_sw is ignored. With mode9=0 and par_en=1 the parity of d0..d6 replaces d7. Parity is even (XOR of the bits) for par_odd=0 and odd (inverted XOR) for par_odd=1.
- R6: A buffered character enters the shifter at the tick where the shifter becomes free. tdre becomes 1 on that same edge, and a character written before the previous frame ends follows it with no idle bit between.
- R7: A host write (wr_stb=1) makes tdre and tc 0 from the next clock edge.
- R8: tc is 1 only while the line is idle with no character, preamble or active break pending. It returns to 1 at the tick after the last stop bit.
- R9: While brk_req is 1 and tx_en is 1, frames of all-zero bits of the full frame length are sent back to back. After brk_req drops, txd is 1 for at least one bit before the next frame starts.
- R10: rx_to_rcv equals txd when loop_en is 1 and rx_pin when loop_en is 0.
- R11: irq is 1 exactly when (tdre and tdre_ie) or (tc and tc_ie).
- R12: Clearing tx_en lets the frame in flight finish. After it, txd stays 1 and a buffered character is not sent (tdre stays 0) until tx_en is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit-time boundary |
| tx_en | input | 1 | Transmitter on |
| mode9 | input | 1 | 0: 8 data bits; 1: 9 data bits |
| par_en | input | 1 | Parity generation on |
| par_odd | input | 1 | 0: even parity; 1: odd parity |
| bit9_sw | input | 1 | Host-supplied ninth data bit |
| brk_req | input | 1 | Send break frames while 1 |
| loop_en | input | 1 | Route txd to the receiver input |
| rx_pin | input | 1 | External receive pin |
| wr_stb | input | 1 | Host write strobe, one cycle per character |
| wr_data | input | 8 | Character written by the host |
| tdre_ie | input | 1 | Interrupt enable for buffer empty |
| tc_ie | input | 1 | Interrupt enable for line complete |
| txd | output | 1 | Serial transmit line, idles high |
| rx_to_rcv | output | 1 | Data input handed to the receiver |
| tdre | output | 1 | Holding buffer empty |
| tc | output | 1 | Line complete, nothing pending |
| irq | output | 1 | Interrupt request |

## Verification
The checks assume that baud_tick is a single-cycle pulse with idle cycles between pulses. They assume that the mode and parity controls are steady at the tick that loads a character. They assume that the host writes only as a one-cycle strobe. The stimulus spaces ticks four idle cycles apart. It changes mode9, par_en, par_odd, bit9_sw, brk_req and tx_en only on falling clock edges away from any tick. It issues every write as a single-cycle strobe. Under those limits the properties cover the following: txd moves only on a tick edge; a write empties neither flag; tdre rises only after a tick; tc implies a high line; and irq has a live source.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_PRE  = 3'd1,
        S_BRK  = 3'd2,
        S_MARK = 3'd3,
        S_DATA = 3'd4
    } tx_state_e;

endpackage

// File: rtl/sertx_parity.sv
module sertx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              mode9,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              bit9_sw,
    output logic [DATA_W-1:0] body,
    output logic              xbit
);
    localparam int TOP = DATA_W - 1;

    logic [DATA_W-1:0] chain;

    assign chain[0] = raw[0];
    for (genvar g = 1; g < DATA_W; g++) begin : g_xor
        assign chain[g] = chain[g-1] ^ raw[g];
    end

    logic par_low;
    logic par_all;

    assign par_low = chain[TOP-1] ^ par_odd;
    assign par_all = chain[TOP] ^ par_odd;

    always_comb begin
        body      = raw;
        body[TOP] = (!mode9 && par_en) ? par_low : raw[TOP];
        xbit      = par_en ? par_all : bit9_sw;
    end

endmodule

// File: rtl/sertx_buffer.sv
module sertx_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            full      <= 1'b0;
        end else if (wr_stb) begin
            hold_data <= wr_data;
            full      <= 1'b1;
        end else if (take) begin
            full      <= 1'b0;
        end
    end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
    parameter int FR_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld,
    input  logic [FR_W-1:0] frame,
    input  logic            adv,
    output logic            txd
);
    logic [FR_W-2:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd <= 1'b1;
            sh  <= '1;
        end else if (ld) begin
            txd <= frame[0];
            sh  <= frame[FR_W-1:1];
        end else if (adv) begin
            txd <= sh[0];
            sh  <= {1'b1, sh[FR_W-2:1]};
        end
    end

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int FR_W = 11
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      baud_tick,
    input  logic      tx_en,
    input  logic      brk_req,
    input  logic      buf_full,
    input  logic      mode9,
    output tx_state_e load_kind,
    output logic      ld,
    output logic      take,
    output logic      tc
);
    localparam int CW = $clog2(FR_W + 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(FR_W - 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(FR_W - 2);

    tx_state_e     state;
    tx_state_e     nxt;
    logic [CW-1:0] cnt;
    logic          pre_q;
    logic          en_d;
    logic          en_rise;
    logic          pre_want;
    logic          free;
    logic          step;

    assign en_rise  = tx_en && !en_d;
    assign pre_want = pre_q || en_rise;
    assign free     = (state == S_IDLE) || (cnt == '0);
    assign step     = baud_tick && free;

    // next-state decision at a frame boundary
    always_comb begin
        nxt = state;
        if (step) begin
            if (!tx_en) begin
                nxt = S_IDLE;
            end else if (pre_want) begin
                nxt = S_PRE;
            end else if (brk_req) begin
                nxt = S_BRK;
            end else begin
                unique case (state)
                    S_BRK:                        nxt = S_MARK;
                    S_IDLE, S_PRE, S_MARK, S_DATA: nxt = buf_full ? S_DATA : S_IDLE;
                    default:                      nxt = S_IDLE;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // bit counter, preamble queue and enable history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            pre_q <= 1'b0;
            en_d  <= 1'b0;
        end else begin
            en_d <= tx_en;
            if (step) begin
                unique case (nxt)
                    S_PRE, S_BRK, S_DATA: cnt <= mode9 ? LAST_LONG : LAST_SHORT;
                    default:              cnt <= '0;
                endcase
            end else if (baud_tick && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (!tx_en) begin
                pre_q <= 1'b0;
            end else if (step && nxt == S_PRE) begin
                pre_q <= 1'b0;
            end else if (en_rise) begin
                pre_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        load_kind = nxt;
        ld        = step;
        take      = step && (nxt == S_DATA);
        tc        = (state == S_IDLE) && !buf_full && !pre_q && !(tx_en && brk_req);
    end

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              mode9,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              bit9_sw,
    input  logic              brk_req,
    input  logic              loop_en,
    input  logic              rx_pin,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tdre_ie,
    input  logic              tc_ie,
    output logic              txd,
    output logic              rx_to_rcv,
    output logic              tdre,
    output logic              tc,
    output logic              irq
);
    localparam int FR_W = DATA_W + 3;

    logic [DATA_W-1:0] hold_data;
    logic [DATA_W-1:0] body;
    logic              xbit;
    logic              buf_full;
    logic              take;
    logic              ld;
    tx_state_e         load_kind;
    logic [FR_W-1:0]   frame;

    sertx_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .take      (take),
        .hold_data (hold_data),
        .full      (buf_full)
    );

    sertx_parity #(.DATA_W(DATA_W)) u_par (
        .raw     (hold_data),
        .mode9   (mode9),
        .par_en  (par_en),
        .par_odd (par_odd),
        .bit9_sw (bit9_sw),
        .body    (body),
        .xbit    (xbit)
    );

    sertx_fsm #(.FR_W(FR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .tx_en     (tx_en),
        .brk_req   (brk_req),
        .buf_full  (buf_full),
        .mode9     (mode9),
        .load_kind (load_kind),
        .ld        (ld),
        .take      (take),
        .tc        (tc)
    );

    // frame image chosen by what the controller loads next
    always_comb begin
        unique case (load_kind)
            S_DATA:  frame = {1'b1, (mode9 ? xbit : 1'b1), body, 1'b0};
            S_BRK:   frame = '0;
            default: frame = '1;
        endcase
    end

    sertx_shift #(.FR_W(FR_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld),
        .frame (frame),
        .adv   (baud_tick),
        .txd   (txd)
    );

    assign tdre      = !buf_full;
    assign irq       = (tdre && tdre_ie) || (tc && tc_ie);
    assign rx_to_rcv = loop_en ? txd : rx_pin;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic wr_stb,
    input logic txd,
    input logic tdre,
    input logic tc,
    input logic irq
);
    // R3
    txd_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(txd));

    // R7
    wr_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (!tdre && !tc));

    // R6
    tdre_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tdre) |-> $past(baud_tick));

    // R8
    tc_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> txd);

    // R11
    irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tdre || tc));

endmodule

bind sertx_top sertx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .wr_stb    (wr_stb),
    .txd       (txd),
    .tdre      (tdre),
    .tc        (tc),
    .irq       (irq)
);

// File: tb/sertx_top_test.sv
module sertx_top_test;
    localparam int CLK_P = 10;
    localparam int GAP   = 4;

    typedef struct packed {
        logic       m;
        logic       pe;
        logic       pt;
        logic       t8;
        logic [7:0] d;
        logic       x;
    } vec_t;

    // expected extra bit worked out by hand from R5
    localparam vec_t VECS [0:7] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b1},
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'h53, 1'b0},
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'h53, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'h07, 1'b1},
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'h07, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       mode9 = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       bit9_sw = 1'b0;
    logic       brk_req = 1'b0;
    logic       loop_en = 1'b0;
    logic       rx_pin = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tdre_ie = 1'b0;
    logic       tc_ie = 1'b0;
    logic       txd, rx_to_rcv, tdre, tc, irq;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sertx_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .tx_en     (tx_en),
        .mode9     (mode9),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .bit9_sw   (bit9_sw),
        .brk_req   (brk_req),
        .loop_en   (loop_en),
        .rx_pin    (rx_pin),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .tdre_ie   (tdre_ie),
        .tc_ie     (tc_ie),
        .txd       (txd),
        .rx_to_rcv (rx_to_rcv),
        .tdre      (tdre),
        .tc        (tc),
        .irq       (irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one bit time: tick pulse, sample txd after that edge, then idle cycles
    task automatic tick(output logic b);
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
        b = txd;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk) begin wr_stb = 1'b1; wr_data = d; end
        @(negedge clk) wr_stb = 1'b0;
    endtask

    task automatic expect_bits(input string req, input string what, input logic [10:0] exp, input int from, input int upto);
        logic b;
        for (int i = from; i <= upto; i++) begin
            tick(b);
            check(req, $sformatf("%s bit %0d", what, i), b, exp[i]);
        end
    endtask

    function automatic logic [10:0] frame_of(input logic m, input logic [7:0] d, input logic x);
        logic [10:0] f;
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < 7; i++) f[1+i] = d[i];
        if (!m) begin
            f[8] = x;
        end else begin
            f[8] = d[7];
            f[9] = x;
        end
        return f;
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog (all requirements): run did not complete");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic b;
        logic [10:0] f;
        int len;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "txd", txd, 1);
        check("R1", "tdre", tdre, 1);
        check("R1", "tc", tc, 1);
        check("R1", "irq", irq, 0);

        // R3 idle line while disabled
        tick(b); check("R3", "idle txd", b, 1);
        tick(b); check("R3", "idle txd again", b, 1);

        // R2 preamble then first character
        @(negedge clk) tx_en = 1'b1;
        host_write(8'hA5);
        expect_bits("R2", "preamble", 11'h7FF, 0, 9);
        check("R2", "tdre held during preamble", tdre, 0);
        f = frame_of(1'b0, 8'hA5, 1'b1);
        tick(b);
        check("R6", "start after preamble", b, 0);
        check("R6", "tdre at load", tdre, 1);
        expect_bits("R4", "first frame", f, 1, 9);
        tick(b);
        check("R8", "idle after frame", b, 1);
        check("R8", "tc after frame", tc, 1);

        // vector table: formats and the extra bit
        for (int v = 0; v < 8; v++) begin
            @(negedge clk) begin
                mode9 = VECS[v].m; par_en = VECS[v].pe;
                par_odd = VECS[v].pt; bit9_sw = VECS[v].t8;
            end
            host_write(VECS[v].d);
            check("R7", $sformatf("v%0d tdre after write", v), tdre, 0);
            check("R7", $sformatf("v%0d tc after write", v), tc, 0);
            f = frame_of(VECS[v].m, VECS[v].d, VECS[v].x);
            len = VECS[v].m ? 11 : 10;
            tick(b);
            check("R4", $sformatf("v%0d start", v), b, 0);
            check("R6", $sformatf("v%0d tdre at load", v), tdre, 1);
            expect_bits("R5", $sformatf("v%0d frame", v), f, 1, len - 1);
            tick(b);
            check("R8", $sformatf("v%0d tc at end", v), tc, 1);
        end
        @(negedge clk) begin mode9 = 1'b0; par_en = 1'b0; par_odd = 1'b0; bit9_sw = 1'b0; end

        // R6 back-to-back frames without gap
        host_write(8'h3A);
        tick(b);
        check("R6", "b2b first start", b, 0);
        host_write(8'hC6);
        expect_bits("R6", "b2b first", frame_of(1'b0, 8'h3A, 1'b0), 1, 9);
        tick(b);
        check("R6", "b2b second start no gap", b, 0);
        expect_bits("R6", "b2b second", frame_of(1'b0, 8'hC6, 1'b1), 1, 9);
        tick(b);
        check("R8", "tc after b2b", tc, 1);

        // R9 break frames, then a high bit before data
        @(negedge clk) brk_req = 1'b1;
        @(negedge clk);
        check("R8", "tc with break pending", tc, 0);
        host_write(8'h0F);
        expect_bits("R9", "break zeros", 11'h000, 0, 9);
        check("R9", "tdre held during break", tdre, 0);
        @(negedge clk) brk_req = 1'b0;
        tick(b);
        check("R9", "mark bit after break", b, 1);
        tick(b);
        check("R9", "start after mark", b, 0);
        expect_bits("R9", "frame after break", frame_of(1'b0, 8'h0F, 1'b0), 1, 9);
        tick(b);

        // R10 loopback
        @(negedge clk) rx_pin = 1'b0;
        #1 check("R10", "no loop follows pin", rx_to_rcv, 0);
        @(negedge clk) begin rx_pin = 1'b1; loop_en = 1'b1; end
        host_write(8'h55);
        tick(b);
        check("R10", "loop carries start bit", rx_to_rcv, 0);
        expect_bits("R10", "loop frame", frame_of(1'b0, 8'h55, 1'b0), 1, 9);
        tick(b);
        check("R10", "loop idle high", rx_to_rcv, 1);
        @(negedge clk) loop_en = 1'b0;

        // R11 interrupt gating
        @(negedge clk) begin tdre_ie = 1'b1; tc_ie = 1'b0; end
        #1 check("R11", "tdre source", irq, 1);
        @(negedge clk) begin tdre_ie = 1'b0; tc_ie = 1'b1; end
        #1 check("R11", "tc source", irq, 1);
        @(negedge clk) tc_ie = 1'b0;
        #1 check("R11", "both masked", irq, 0);
        @(negedge clk) tc_ie = 1'b1;
        host_write(8'h81);
        check("R11", "after write", irq, 0);
        tick(b);
        check("R11", "tc masked tdre off during frame", irq, 0);
        @(negedge clk) tdre_ie = 1'b1;
        #1 check("R11", "tdre after load", irq, 1);
        @(negedge clk) tdre_ie = 1'b0;
        expect_bits("R11", "irq frame", frame_of(1'b0, 8'h81, 1'b1), 1, 9);
        tick(b);
        check("R11", "tc at end", irq, 1);
        @(negedge clk) tc_ie = 1'b0;

        // R12 disable mid-frame
        host_write(8'h96);
        f = frame_of(1'b0, 8'h96, 1'b1);
        expect_bits("R12", "before disable", f, 0, 2);
        @(negedge clk) tx_en = 1'b0;
        expect_bits("R12", "finishes after disable", f, 3, 9);
        host_write(8'h11);
        for (int k = 0; k < 12; k++) begin
            tick(b);
            check("R12", $sformatf("held high %0d", k), b, 1);
        end
        check("R12", "tdre stays 0 while off", tdre, 0);
        @(negedge clk) tx_en = 1'b1;
        expect_bits("R2", "preamble on re-enable", 11'h7FF, 0, 9);
        tick(b);
        check("R2", "start after re-enable preamble", b, 0);
        expect_bits("R4", "frame after re-enable", frame_of(1'b0, 8'h11, 1'b0), 1, 9);
        tick(b);
        check("R8", "tc at finish", tc, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule